// File: doc/BRIEF.md
# Semaphore Command Unit with Transfer Fences

This unit keeps a bank of 32 counting semaphores, each 12 bits wide, and executes 32-bit semaphore command words handed to it by a request sequencer. A command can set, step or test one semaphore. It can also hold off until the counts of outstanding transfers in either direction drain to zero. A command that cannot proceed yet is held inside the unit. While it is held, the unit re-evaluates it every clock and keeps its command input closed. When the command finishes, the unit emits a one-cycle completion that carries the resulting semaphore value, an error flag and the echoed sync-placement bit.

The compute side can step any semaphore up or down by one through a separate port, in the same cycle as sequencer activity. Waiting commands are released by these external steps or by the transfer counters falling to zero. The test-then-decrement command reads and writes its semaphore in a single clock. An external update in that same clock is folded into the result, so no update is lost.

Top module: `semfence_unit`

## Requirements
- R1: Bit 31 of the command word is its enable. A word with bit 31 clear completes one clock after acceptance with `done_err` low and `done_val` zero, and changes no semaphore, whatever its other bits say.
- R2: Bits 26:24 are the opcode, bits 20:16 the semaphore index and bits 11:0 the operand. Opcode 1 loads the operand into the indexed semaphore. Opcode 0 leaves it unchanged. For every executed opcode, `done_val` is the indexed semaphore's value after the completing clock.
- R3: Opcode 2 adds one to the semaphore and opcode 3 subtracts one, both modulo 4096 (4095+1 gives 0, 0-1 gives 4095).
- R4: Opcode 4 is held until the semaphore equals the operand, then completes without changing it.
- R5: Opcode 5 is held until the semaphore is greater than or equal to the operand, then completes without changing it.
- R6: Opcode 6 is held while the semaphore is zero. Once it is nonzero, the command decrements it by one in the same clock as the test.
- R7: With bit 30 set, an enabled command is held while `h2d_cnt` is nonzero. With bit 29 set, it is held while `d2h_cnt` is nonzero. With both bits clear, the counts are ignored.
- R8: Opcode 7 on an enabled word completes one clock after acceptance with `done_err` high. It changes no semaphore and ignores the fence bits.
- R9: A pulse on `ext_valid` adds one to semaphore `ext_idx` (or subtracts one when `ext_dec` is 1), modulo 4096. When this hits the semaphore the sequencer is updating in the same clock, the sequencer's result is applied first and the external step on top of it.
- R10: `cmd_ready` is high while no command is held. A command is accepted on a clock where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` then stays low until the completion clock. `done_valid` is a single-cycle pulse, one clock after acceptance when nothing holds the command.
- R11: `done_pre` reports bit 22 (1 = pre-sync, 0 = post-sync) of the completed command.
- R12: After reset, every semaphore reads 0, `cmd_ready` is high and `done_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_word | input | 32 | Semaphore command word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completed command had the reserved opcode |
| done_pre | output | 1 | Sync-placement bit of the completed command |
| done_val | output | 12 | Indexed semaphore value after completion |
| h2d_cnt | input | CNT_W | Outstanding to-device transfers |
| d2h_cnt | input | CNT_W | Outstanding from-device transfers |
| ext_valid | input | 1 | External step request |
| ext_dec | input | 1 | External step direction, 1 = down |
| ext_idx | input | 5 | Semaphore index of the external step |

## Verification
The hardest case to reach is an external step landing on a semaphore in the exact clock in which a held or immediate command updates that same entry. That collision decides whether the net update is correct. The bench reaches it by raising the external pulse at the falling edge that directly follows acceptance, so that the pulse and the command's first evaluation meet at the same rising edge. It also releases held waits by stepping the semaphore from outside one clock at a time, and checks that release happens exactly one clock after the condition first holds in stored state.

// File: rtl/semfence_pkg.sv
package semfence_pkg;
  localparam int WORD_W = 32;
  localparam int VAL_W  = 12;
  localparam int IDX_W  = 5;
  localparam int NSEM   = 1 << IDX_W;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SET  = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_WEQ  = 3'd4,
    OP_WGE  = 3'd5,
    OP_TAKE = 3'd6,
    OP_BAD  = 3'd7
  } sem_op_e;

  // field positions follow the command word layout decoded by the sequencer
  typedef struct packed {
    logic             en;        // 31
    logic             fence_h2d; // 30
    logic             fence_d2h; // 29
    logic [1:0]       rsv_a;     // 28:27
    sem_op_e          op;        // 26:24
    logic             rsv_b;     // 23
    logic             pre;       // 22
    logic             rsv_c;     // 21
    logic [IDX_W-1:0] idx;       // 20:16
    logic [3:0]       rsv_d;     // 15:12
    logic [VAL_W-1:0] val;       // 11:0
  } sem_word_t;
endpackage

// File: rtl/semfence_eval.sv
module semfence_eval
  import semfence_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  sem_word_t        word,
  input  logic [VAL_W-1:0] cur,
  input  logic [CNT_W-1:0] h2d_cnt,
  input  logic [CNT_W-1:0] d2h_cnt,
  output logic             fire,
  output logic             err,
  output logic             wr_en,
  output logic [VAL_W-1:0] base
);
  logic fence_ok;
  logic cond_ok;

  always_comb begin
    fence_ok = !(word.fence_h2d && (h2d_cnt != '0)) &&
               !(word.fence_d2h && (d2h_cnt != '0));
    cond_ok  = 1'b1;
    wr_en    = 1'b0;
    base     = cur;
    unique case (word.op)
      OP_SET:  begin wr_en = 1'b1; base = word.val; end
      OP_INC:  begin wr_en = 1'b1; base = cur + 1'b1; end
      OP_DEC:  begin wr_en = 1'b1; base = cur - 1'b1; end
      OP_WEQ:  cond_ok = (cur == word.val);
      OP_WGE:  cond_ok = (cur >= word.val);
      OP_TAKE: begin cond_ok = (cur != '0); wr_en = 1'b1; base = cur - 1'b1; end
      default: ;
    endcase
    err   = word.en && (word.op == OP_BAD);
    fire  = !word.en || err || (fence_ok && cond_ok);
    wr_en = wr_en && word.en && !err;
  end
endmodule

// File: rtl/semfence_bank.sv
module semfence_bank
  import semfence_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] seq_idx,
  input  logic             seq_we,
  input  logic [VAL_W-1:0] seq_base,
  input  logic             ext_en,
  input  logic             ext_dec,
  input  logic [IDX_W-1:0] ext_idx,
  output logic [VAL_W-1:0] rd_val,
  output logic [VAL_W-1:0] seq_next
);
  logic [VAL_W-1:0] mem [NSEM];
  logic [VAL_W-1:0] nxt [NSEM];

  always_comb begin
    for (int i = 0; i < NSEM; i++) begin
      logic [VAL_W-1:0] b;
      b = mem[i];
      if (seq_we && (seq_idx == IDX_W'(i))) b = seq_base;
      if (ext_en && (ext_idx == IDX_W'(i)))
        nxt[i] = ext_dec ? b - 1'b1 : b + 1'b1;
      else
        nxt[i] = b;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSEM; i++) begin
      if (rst) mem[i] <= '0;
      else     mem[i] <= nxt[i];
    end
  end

  assign rd_val   = mem[seq_idx];
  assign seq_next = nxt[seq_idx];
endmodule

// File: rtl/semfence_unit.sv
module semfence_unit
  import semfence_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  output logic             done_valid,
  output logic             done_err,
  output logic             done_pre,
  output logic [VAL_W-1:0] done_val,
  input  logic [CNT_W-1:0] h2d_cnt,
  input  logic [CNT_W-1:0] d2h_cnt,
  input  logic             ext_valid,
  input  logic             ext_dec,
  input  logic [IDX_W-1:0] ext_idx
);
  logic             busy;
  sem_word_t        cmd_q;
  logic [VAL_W-1:0] cur;
  logic [VAL_W-1:0] base;
  logic [VAL_W-1:0] nxt_val;
  logic             fire, err, wr_en;

  semfence_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .seq_idx  (cmd_q.idx),
    .seq_we   (busy && fire && wr_en),
    .seq_base (base),
    .ext_en   (ext_valid),
    .ext_dec  (ext_dec),
    .ext_idx  (ext_idx),
    .rd_val   (cur),
    .seq_next (nxt_val)
  );

  semfence_eval #(.CNT_W(CNT_W)) u_eval (
    .word    (cmd_q),
    .cur     (cur),
    .h2d_cnt (h2d_cnt),
    .d2h_cnt (d2h_cnt),
    .fire    (fire),
    .err     (err),
    .wr_en   (wr_en),
    .base    (base)
  );

  assign cmd_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cmd_q      <= '0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      done_pre   <= 1'b0;
      done_val   <= '0;
    end else begin
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      if (busy && fire) begin
        busy       <= 1'b0;
        done_valid <= 1'b1;
        done_err   <= err;
        done_pre   <= cmd_q.pre;
        done_val   <= (cmd_q.en && !err) ? nxt_val : '0;
      end else if (!busy && cmd_valid) begin
        busy  <= 1'b1;
        cmd_q <= sem_word_t'(cmd_word);
      end
    end
  end
endmodule

// File: rtl/semfence_chk.sv
module semfence_chk
  import semfence_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              done_valid,
  input logic              done_err,
  input logic [CNT_W-1:0]  h2d_cnt,
  input logic [CNT_W-1:0]  d2h_cnt,
  input logic              busy,
  input logic [WORD_W-1:0] cmd_q
);
  // R10
  accept_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R10
  done_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(!cmd_ready));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  // R7
  fence_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_q[31] && (cmd_q[26:24] != 3'd7) &&
     ((cmd_q[30] && h2d_cnt != '0) || (cmd_q[29] && d2h_cnt != '0)))
    |=> !done_valid);

  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    done_err |-> (done_valid && $past(cmd_q[31] && cmd_q[26:24] == 3'd7)));
endmodule

bind semfence_unit semfence_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .done_valid (done_valid),
  .done_err   (done_err),
  .h2d_cnt    (h2d_cnt),
  .d2h_cnt    (d2h_cnt),
  .busy       (busy),
  .cmd_q      (cmd_q)
);

// File: tb/sim_semfence_unit.sv
module sim_semfence_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic        done_valid, done_err, done_pre;
  logic [11:0] done_val;
  logic [7:0]  h2d_cnt = '0;
  logic [7:0]  d2h_cnt = '0;
  logic        ext_valid = 1'b0;
  logic        ext_dec = 1'b0;
  logic [4:0]  ext_idx = '0;

  int errs = 0;
  int checks = 0;
  logic [11:0] model [32];

  always #4 clk = ~clk;

  semfence_unit u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .done_valid(done_valid), .done_err(done_err),
    .done_pre(done_pre), .done_val(done_val), .h2d_cnt(h2d_cnt),
    .d2h_cnt(d2h_cnt), .ext_valid(ext_valid), .ext_dec(ext_dec),
    .ext_idx(ext_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit fh, input bit fd,
      input int op, input bit pre, input int idx, input int val);
    logic [31:0] w;
    w = '0;
    w[31] = en; w[30] = fh; w[29] = fd;
    w[26:24] = op[2:0]; w[22] = pre;
    w[20:16] = idx[4:0]; w[11:0] = val[11:0];
    return w;
  endfunction

  // accept one word; returns at the falling edge after the accepting edge
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int maxc, output int cyc);
    cyc = 0;
    while (!done_valid && cyc < maxc) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(input logic [31:0] w, output int val, output bit er,
                     output bit pr, output int cyc);
    send(w);
    wait_done(40, cyc);
    val = done_val; er = done_err; pr = done_pre;
  endtask

  task automatic hold_check(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      chk(!done_valid && !cmd_ready, req, done_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic ext_step(input int idx, input bit dn);
    ext_valid = 1'b1; ext_idx = idx[4:0]; ext_dec = dn;
    @(negedge clk);
    ext_valid = 1'b0;
  endtask

  task automatic readback(input int idx, input string req);
    int v, c; bit e, p;
    run(mk(1, 0, 0, 0, 0, idx, 0), v, e, p, c);
    chk(v == model[idx] && c == 1, req, v, model[idx]);
  endtask

  task automatic load(input int idx, input int val);
    int v, c; bit e, p;
    run(mk(1, 0, 0, 1, 0, idx, val), v, e, p, c);
    model[idx] = val[11:0];
    chk(v == val && c == 1, "R2 load", v, val);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int v, c; bit e, p;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(cmd_ready == 1'b1, "R12 ready", cmd_ready, 1);
    chk(done_valid == 1'b0, "R12 done", done_valid, 0);
    for (int i = 0; i < 32; i++) readback(i, "R12 zero");

    // R2 sweep load then read every index
    for (int i = 0; i < 32; i++) load(i, (i * 131 + 7) % 4096);
    for (int i = 0; i < 32; i++) readback(i, "R2 read");

    // R10 ready closes right after acceptance
    send(mk(1, 0, 0, 0, 0, 1, 0));
    chk(!cmd_ready && !done_valid, "R10 closed", cmd_ready, 0);
    wait_done(40, c);
    chk(c == 1 && cmd_ready, "R10 latency", c, 1);
    @(negedge clk);
    chk(!done_valid, "R10 pulse", done_valid, 0);

    // R3 step and wrap
    for (int i = 0; i < 8; i++) begin
      run(mk(1, 0, 0, 2, 0, i, 0), v, e, p, c);
      model[i] = model[i] + 1;
      chk(v == model[i], "R3 inc", v, model[i]);
      run(mk(1, 0, 0, 3, 0, i + 8, 0), v, e, p, c);
      model[i + 8] = model[i + 8] - 1;
      chk(v == model[i + 8], "R3 dec", v, model[i + 8]);
    end
    load(12, 4095);
    run(mk(1, 0, 0, 2, 0, 12, 0), v, e, p, c);
    model[12] = 0;
    chk(v == 0, "R3 wrap up", v, 0);
    run(mk(1, 0, 0, 3, 0, 12, 0), v, e, p, c);
    model[12] = 4095;
    chk(v == 4095, "R3 wrap down", v, 4095);

    // R1 disabled word, even with fence and counts
    h2d_cnt = 8'd4;
    run(mk(0, 1, 0, 1, 0, 3, 999), v, e, p, c);
    chk(c == 1 && v == 0 && !e, "R1 disabled", v, 0);
    h2d_cnt = 8'd0;
    readback(3, "R1 unchanged");

    // R8 reserved opcode ignores fences, flags error
    h2d_cnt = 8'd5; d2h_cnt = 8'd2;
    run(mk(1, 1, 1, 7, 0, 4, 55), v, e, p, c);
    chk(c == 1 && e, "R8 error", e, 1);
    h2d_cnt = 8'd0; d2h_cnt = 8'd0;
    readback(4, "R8 unchanged");

    // R11 sync bit echo
    run(mk(1, 0, 0, 0, 1, 2, 0), v, e, p, c);
    chk(p == 1'b1, "R11 pre", p, 1);
    run(mk(1, 0, 0, 0, 0, 2, 0), v, e, p, c);
    chk(p == 1'b0, "R11 post", p, 0);

    // R7 fences
    h2d_cnt = 8'd2;
    send(mk(1, 1, 0, 0, 0, 0, 0));
    hold_check("R7 to-device hold", 5);
    h2d_cnt = 8'd0;
    wait_done(40, c);
    chk(c == 1, "R7 to-device release", c, 1);
    d2h_cnt = 8'd3;
    send(mk(1, 0, 1, 0, 0, 0, 0));
    hold_check("R7 from-device hold", 5);
    d2h_cnt = 8'd0;
    wait_done(40, c);
    chk(c == 1, "R7 from-device release", c, 1);
    h2d_cnt = 8'd9; d2h_cnt = 8'd9;
    run(mk(1, 0, 0, 0, 0, 0, 0), v, e, p, c);
    chk(c == 1, "R7 unfenced ignores counts", c, 1);
    h2d_cnt = 8'd0; d2h_cnt = 8'd0;

    // R4 wait equal, released by external steps
    load(5, 3);
    send(mk(1, 0, 0, 4, 0, 5, 5));
    hold_check("R4 hold", 3);
    ext_step(5, 0);
    ext_step(5, 0);
    wait_done(40, c);
    chk(c == 1 && done_val == 5, "R4 release", done_val, 5);
    model[5] = 5;

    // R5 wait greater or equal
    load(6, 7);
    run(mk(1, 0, 0, 5, 0, 6, 7), v, e, p, c);
    chk(c == 1 && v == 7, "R5 immediate", v, 7);
    send(mk(1, 0, 0, 5, 0, 6, 9));
    hold_check("R5 hold", 3);
    ext_step(6, 0);
    ext_step(6, 0);
    wait_done(40, c);
    chk(c == 1 && done_val == 9, "R5 release", done_val, 9);
    model[6] = 9;

    // R6 take: hold at zero, then decrement
    load(7, 0);
    send(mk(1, 0, 0, 6, 0, 7, 0));
    hold_check("R6 hold", 4);
    ext_step(7, 0);
    wait_done(40, c);
    chk(c == 1 && done_val == 0, "R6 release", done_val, 0);
    load(7, 2);
    run(mk(1, 0, 0, 6, 0, 7, 0), v, e, p, c);
    model[7] = 1;
    chk(c == 1 && v == 1, "R6 immediate", v, 1);

    // R9 same-cycle collisions and plain external steps
    load(8, 1);
    send(mk(1, 0, 0, 6, 0, 8, 0));
    ext_step(8, 0);
    chk(done_valid && done_val == 1, "R9 take plus ext", done_val, 1);
    model[8] = 1;
    send(mk(1, 0, 0, 1, 0, 8, 100));
    ext_step(8, 1);
    chk(done_valid && done_val == 99, "R9 load plus ext", done_val, 99);
    model[8] = 99;
    load(9, 10);
    send(mk(1, 0, 0, 2, 0, 9, 0));
    ext_step(10, 0);
    model[9] = 11; model[10] = model[10] + 1;
    chk(done_valid && done_val == 11, "R9 other index", done_val, 11);
    readback(10, "R9 other index");
    load(11, 0);
    ext_step(11, 1);
    model[11] = 4095;
    readback(11, "R9 ext wrap");

    // final sweep against the model
    for (int i = 0; i < 32; i++) readback(i, "R2 final");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule